// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

This peripheral holds a 16-bit count that climbs from 0000h to a programmable terminal value and then starts again at 0000h. Software reaches it through a small synchronous register bus with three words: control, count and a shared terminal/capture word. The count advances either on a prescaled system clock (divide by 1 to 128) or on rising edges of an external count pin. Both external pins pass through a two-flop synchronizer before any edge is taken from them.

A second external pin, the event pin, adds to this. Its falling edge can force the count back to zero or take a snapshot of the count into the shared word. In up/down mode its level instead steers the direction of counting. A clock-output mode drives the count pin as an output and toggles it on every wrap. An overflow flag and an event flag are sticky, and they raise an interrupt request when it is enabled.

Top module: `tmr16_multimode`

## Requirements
- R1: Word addresses are 0 = control, 1 = count, 2 = terminal/capture. A read returns the addressed word on `bus_rdata` one clock after the address is presented. Control bits: 0 capture select, 1 run, 2 event enable, 3 up/down enable, 4 output enable, 5 count-pin source, 8:6 prescale, 9 interrupt enable, 10 overflow flag, 11 event flag. After reset the control word is 0, the count is 0000h, the terminal word is FFFFh, and `irq_o` and `cnt_pin_oe` are 0.
- R2: With run set and source 0, the count advances once every 2^prescale system clocks. With run clear, the count holds.
- R3: Counting up, a count step taken while the count equals the terminal word loads 0000h. The overflow flag is set on that same clock edge, which is one clock after the count reached the terminal value at divide-by-1.
- R4: A bus write to the count word takes priority over counting in the same cycle, and counting continues from the written value.
- R5: In reload mode, with event enable set, a falling edge on the synchronized event pin clears the count and sets the event flag. This happens even while run is clear.
- R6: With event enable clear, falling edges on the event pin neither change the count nor set the event flag.
- R7: In capture mode (capture select 1, event enable 1), a falling edge on the event pin copies the count into the terminal/capture word and sets the event flag. The count is left unchanged.
- R8: With source 1, the count advances once per rising edge of the synchronized count pin.
- R9: In up/down mode (up/down enable 1, event enable 0, capture 0, output 0), the count goes up while the event pin is high and down while it is low. Counting down from 0000h loads the terminal word and sets the overflow flag.
- R10: In clock-output mode (output enable 1, source 0, capture 0), `cnt_pin_oe` is 1 and `cnt_pin_o` toggles on each wrap to 0000h. In every other mode `cnt_pin_o` holds.
- R11: The flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A flag event in the same cycle as a clearing write wins.
- R12: `irq_o` is 1 one clock after interrupt enable is set together with either flag, and it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cnt_pin_i | input | 1 | External count pin, input side |
| cnt_pin_o | output | 1 | Count pin drive value in clock-output mode |
| cnt_pin_oe | output | 1 | Count pin output enable |
| evt_pin_i | input | 1 | External event/direction pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench runs the count exactly to the terminal value and exactly one step past it. A design that wraps one step early, or that sets the overflow flag a clock late, shows up as a wrong count or a missing flag at the stop point. It fires event edges while the timer is stopped and while event enable is clear, which catches a run-gated event flag or a pin that is never ignored. It also checks that a capture leaves the count alone, that counting down wraps to the terminal value rather than to FFFFh, that a count write wins over a count step in the same cycle, and that writing 1 to a flag bit neither sets nor clears it.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  localparam int PS_W = 3;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_TERM = 2'd2;

  typedef struct packed {
    logic            ext_flag;
    logic            ovf_flag;
    logic            irq_en;
    logic [PS_W-1:0] ps;
    logic            src_pin;
    logic            out_en;
    logic            dir_en;
    logic            ext_en;
    logic            run;
    logic            cap_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    M_RELOAD,
    M_CAPTURE,
    M_UPDOWN,
    M_CLKOUT
  } mode_e;

  function automatic mode_e decode_mode(input ctrl_t c);
    if (c.out_en && !c.src_pin && !c.cap_sel) return M_CLKOUT;
    if (c.cap_sel)                            return M_CAPTURE;
    if (c.dir_en)                             return M_UPDOWN;
    return M_RELOAD;
  endfunction

endpackage

// File: rtl/tmr16_sync.sv
module tmr16_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      prev  <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] lim;

  always_comb begin
    lim  = (PC_W'(1) << ps) - PC_W'(1);
    tick = en && (pc == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || !en || tick) pc <= '0;
    else                    pc <= pc + 1'b1;
  end
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             up,
  input  logic [CNT_W-1:0] term,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic at_term;
  logic at_zero;

  always_comb begin
    at_term = (count == term);
    at_zero = (count == '0);
    wrap    = !ld_en && !clr && step && (up ? at_term : at_zero);
  end

  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (ld_en) count <= ld_val;
    else if (clr)   count <= '0;
    else if (step) begin
      if (up) count <= at_term ? '0 : count + 1'b1;
      else    count <= at_zero ? term : count - 1'b1;
    end
  end
endmodule

// File: rtl/tmr16_multimode.sv
module tmr16_multimode
  import tmr16_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             cnt_pin_i,
  output logic             cnt_pin_o,
  output logic             cnt_pin_oe,
  input  logic             evt_pin_i,
  output logic             irq_o
);
  localparam int NPIN = 2;

  ctrl_t            ctrl_q;
  ctrl_t            wr_c;
  mode_e            mode;
  logic [CNT_W-1:0] term_q;
  logic [CNT_W-1:0] count;
  logic             wrap;

  logic [NPIN-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  logic cnt_rise, evt_lvl, evt_fall;
  logic presc_tick, step, up_dir;
  logic evt_act, ext_rld, cap_evt, clkout_mode;
  logic wr_ctrl, wr_cnt, wr_term;
  logic ovf_set, ext_set;
  logic pin_o_q, oe_q, irq_q;

  assign pin_raw = {evt_pin_i, cnt_pin_i};

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    tmr16_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .d    (pin_raw[i]),
      .q    (pin_lvl[i]),
      .rise (pin_rise[i]),
      .fall (pin_fall[i])
    );
  end

  always_comb begin
    cnt_rise    = pin_rise[0];
    evt_lvl     = pin_lvl[1];
    evt_fall    = pin_fall[1];
    mode        = decode_mode(ctrl_q);
    clkout_mode = (mode == M_CLKOUT);
    wr_c        = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    wr_ctrl     = bus_we && (bus_addr == A_CTRL);
    wr_cnt      = bus_we && (bus_addr == A_CNT);
    wr_term     = bus_we && (bus_addr == A_TERM);
    step        = ctrl_q.run && (ctrl_q.src_pin ? (cnt_rise && !clkout_mode) : presc_tick);
    up_dir      = (mode != M_UPDOWN) || evt_lvl;
    evt_act     = ctrl_q.ext_en && evt_fall && (mode != M_UPDOWN);
    ext_rld     = evt_act && ((mode == M_RELOAD) || (mode == M_CLKOUT));
    cap_evt     = evt_act && (mode == M_CAPTURE);
    ovf_set     = wrap;
    ext_set     = evt_act;
  end

  tmr16_prescale #(.PS_W(PS_W)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .en   (ctrl_q.run && !ctrl_q.src_pin),
    .ps   (ctrl_q.ps),
    .tick (presc_tick)
  );

  tmr16_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .up     (up_dir),
    .term   (term_q),
    .ld_en  (wr_cnt),
    .ld_val (bus_wdata),
    .clr    (ext_rld),
    .count  (count),
    .wrap   (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q          <= wr_c;
      ctrl_q.ovf_flag <= (ctrl_q.ovf_flag & wr_c.ovf_flag) | ovf_set;
      ctrl_q.ext_flag <= (ctrl_q.ext_flag & wr_c.ext_flag) | ext_set;
    end else begin
      ctrl_q.ovf_flag <= ctrl_q.ovf_flag | ovf_set;
      ctrl_q.ext_flag <= ctrl_q.ext_flag | ext_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          term_q <= '1;
    else if (wr_term) term_q <= bus_wdata;
    else if (cap_evt) term_q <= count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o_q <= 1'b0;
      oe_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (clkout_mode && wrap) pin_o_q <= ~pin_o_q;
      oe_q  <= clkout_mode;
      irq_q <= ctrl_q.irq_en && (ctrl_q.ovf_flag || ctrl_q.ext_flag);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= CNT_W'(ctrl_q);
        A_CNT:   bus_rdata <= count;
        A_TERM:  bus_rdata <= term_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign cnt_pin_o  = pin_o_q;
  assign cnt_pin_oe = oe_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/tmr16_multimode_chk.sv
module tmr16_multimode_chk
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] term_q,
  input logic             step,
  input logic             up_dir,
  input logic             ext_rld,
  input logic             ovf_flag,
  input logic             ext_flag,
  input logic             ext_en,
  input logic             clkout_mode,
  input logic             cnt_pin_o,
  input logic             irq_o
);
  logic wr_cnt_c, wr_ctrl_c;
  assign wr_cnt_c  = bus_we && (bus_addr == A_CNT);
  assign wr_ctrl_c = bus_we && (bus_addr == A_CTRL);

  a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (step && up_dir && (count == term_q) && !wr_cnt_c && !ext_rld) |=> (count == '0 && ovf_flag));

  a_r4_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_cnt_c |=> (count == $past(bus_wdata)));

  a_r6_no_ext_flag: assert property (@(posedge clk) disable iff (rst)
    (!ext_en && !ext_flag) |=> !ext_flag);

  a_r10_pin_quiet: assert property (@(posedge clk) disable iff (rst)
    !clkout_mode |=> $stable(cnt_pin_o));

  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !wr_ctrl_c) |=> ovf_flag);

  a_r11_ext_sticky: assert property (@(posedge clk) disable iff (rst)
    (ext_flag && !wr_ctrl_c) |=> ext_flag);

  a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ovf_flag || ext_flag));
endmodule

bind tmr16_multimode tmr16_multimode_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .count       (count),
  .term_q      (term_q),
  .step        (step),
  .up_dir      (up_dir),
  .ext_rld     (ext_rld),
  .ovf_flag    (ctrl_q.ovf_flag),
  .ext_flag    (ctrl_q.ext_flag),
  .ext_en      (ctrl_q.ext_en),
  .clkout_mode (clkout_mode),
  .cnt_pin_o   (cnt_pin_o),
  .irq_o       (irq_o)
);

// File: tb/tb_tmr16_multimode.sv
`timescale 1ns/1ps
module tb_tmr16_multimode;
  localparam logic [1:0] AC = 2'd0, AN = 2'd1, AT = 2'd2;
  localparam logic [15:0] CAP = 16'h0001, RUN = 16'h0002, EXTEN = 16'h0004,
    DIR = 16'h0008, OUTE = 16'h0010, SRC = 16'h0020, IRQEN = 16'h0200,
    OVF = 16'h0400, EXTF = 16'h0800, STOP = 16'h0C00;

  logic clk = 0, rst = 1;
  logic bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic cnt_pin_i = 0, cnt_pin_o, cnt_pin_oe, evt_pin_i = 0, irq_o;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr16_multimode dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic evt_fall();
    @(negedge clk); evt_pin_i = 1; repeat (6) @(negedge clk);
    evt_pin_i = 0; repeat (6) @(negedge clk);
  endtask

  task automatic cnt_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_pin_i = 1; repeat (4) @(negedge clk);
      cnt_pin_i = 0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic run_n(input int n);
    wr(AC, RUN);
    repeat (n - 1) @(posedge clk);
    wr(AC, STOP);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(AC, v); chk("R1 ctrl reset", v, 16'h0000);
    rd(AN, v); chk("R1 count reset", v, 16'h0000);
    rd(AT, v); chk("R1 term reset", v, 16'hFFFF);
    chk("R1 irq reset", {15'b0, irq_o}, 16'h0);
    chk("R1 oe reset", {15'b0, cnt_pin_oe}, 16'h0);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    wr(AC, 0); wr(AN, 0); wr(AT, 16'd1000);
    wr(AC, RUN | (16'd2 << 6));
    repeat (39) @(posedge clk);
    wr(AC, STOP | (16'd2 << 6));
    repeat (10) @(negedge clk);
    rd(AN, v); chk("R2 divide by 4 for 40 cycles", v, 16'd10);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    wr(AC, 0); wr(AN, 0); wr(AT, 16'd5); run_n(5);
    rd(AN, v); chk("R3 count at terminal", v, 16'd5);
    rd(AC, v); chk("R3 no flag before wrap", v & OVF, 16'h0);
    wr(AC, 0); wr(AN, 0); run_n(6);
    rd(AN, v); chk("R3 wrap to zero", v, 16'd0);
    rd(AC, v); chk("R3 flag on wrap edge", v & OVF, OVF);
    wr(AC, 0); wr(AN, 0); run_n(8);
    rd(AN, v); chk("R3 counts on after wrap", v, 16'd2);
    repeat (5) @(negedge clk);
    rd(AC, v); chk("R11 flag sticky", v & OVF, OVF);
    wr(AC, OVF);
    rd(AC, v); chk("R11 write 1 keeps flag", v & OVF, OVF);
    wr(AC, 0);
    rd(AC, v); chk("R11 write 0 clears flag", v & OVF, 16'h0);
    wr(AC, OVF);
    rd(AC, v); chk("R11 write 1 does not set", v & OVF, 16'h0);
  endtask

  task automatic t_write_prio();
    logic [15:0] v;
    wr(AC, 0); wr(AT, 16'd1000); wr(AN, 0); wr(AC, RUN);
    wr(AN, 16'd100); wr(AC, STOP);
    rd(AN, v); chk("R4 write wins then counts", v, 16'd102);
  endtask

  task automatic t_ext_reload();
    logic [15:0] v;
    wr(AC, 0); wr(AN, 16'd50); wr(AC, EXTEN);
    evt_fall();
    rd(AN, v); chk("R5 event clears count while stopped", v, 16'd0);
    rd(AC, v); chk("R5 event flag while stopped", v & EXTF, EXTF);
    wr(AC, 0); wr(AN, 16'd50);
    evt_fall();
    rd(AN, v); chk("R6 pin ignored count", v, 16'd50);
    rd(AC, v); chk("R6 pin ignored flag", v & EXTF, 16'h0);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    wr(AC, 0); wr(AT, 16'd999); wr(AN, 16'd77);
    wr(AC, CAP | EXTEN | RUN | SRC);
    evt_fall();
    rd(AT, v); chk("R7 captured value", v, 16'd77);
    rd(AN, v); chk("R7 count untouched", v, 16'd77);
    rd(AC, v); chk("R7 event flag", v & EXTF, EXTF);
  endtask

  task automatic t_pin_count();
    logic [15:0] v;
    wr(AC, 0); wr(AT, 16'd1000); wr(AN, 0); wr(AC, RUN | SRC);
    cnt_pulses(3);
    rd(AN, v); chk("R8 three pin pulses", v, 16'd3);
  endtask

  task automatic t_updown();
    logic [15:0] v;
    wr(AC, 0); wr(AT, 16'd9); wr(AN, 16'd2);
    evt_pin_i = 0; repeat (6) @(negedge clk);
    wr(AC, RUN | SRC | DIR);
    cnt_pulses(3);
    rd(AN, v); chk("R9 down wraps to terminal", v, 16'd9);
    rd(AC, v); chk("R9 underflow flag", v & OVF, OVF);
    evt_pin_i = 1; repeat (6) @(negedge clk);
    cnt_pulses(2);
    rd(AN, v); chk("R9 up after wrap", v, 16'd1);
    wr(AC, 0); evt_pin_i = 0; repeat (6) @(negedge clk);
  endtask

  task automatic t_clkout();
    logic p; int tog = 0;
    wr(AC, 0); wr(AT, 16'd3); wr(AN, 0);
    wr(AC, OUTE | RUN);
    p = cnt_pin_o;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (cnt_pin_o !== p) tog++;
      p = cnt_pin_o;
    end
    chk("R10 four toggles in 16 cycles", 16'(tog), 16'd4);
    chk("R10 output enabled", {15'b0, cnt_pin_oe}, 16'h1);
    wr(AC, 0); repeat (3) @(negedge clk);
    chk("R10 output released", {15'b0, cnt_pin_oe}, 16'h0);
  endtask

  task automatic t_irq();
    wr(AC, 0); wr(AC, IRQEN); repeat (2) @(negedge clk);
    chk("R12 no flag no irq", {15'b0, irq_o}, 16'h0);
    wr(AC, IRQEN | EXTEN);
    evt_fall();
    chk("R12 irq on event flag", {15'b0, irq_o}, 16'h1);
    wr(AC, IRQEN | EXTEN); repeat (2) @(negedge clk);
    chk("R12 irq drops after clear", {15'b0, irq_o}, 16'h0);
    wr(AC, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_prescale();
    t_wrap();
    t_write_prio();
    t_ext_reload();
    t_capture();
    t_pin_count();
    t_updown();
    t_clkout();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule